// File: doc/BRIEF.md
# Memory Profile Header Checker

This block walks the header of an extended memory-profile region held in a byte-addressable configuration store. A single `start` pulse sets it off. It then issues reads on a simple synchronous port: one address per request, with data returned one cycle later. It checks the two identifier bytes, the organization byte and the revision byte. If any check fails, it stops at once and flags an error.

When the header is accepted, the block reports three things for each of the two profiles: whether the profile is enabled, the recommended number of modules per channel, and the timebase dividend and divisor to use. A minor revision of zero means both profiles share the first timebase pair. Any later minor revision gives the second profile its own pair. Converting timings into clock counts is left to the logic downstream.

Top module: `prof_hdr_check`

## Requirements
- R1: An accepted `start` issues reads from address 176 upward, one address higher per request, with one request every two cycles, never more than one outstanding, and never above address 183.
- R2: Byte 176 must read 0x0C and byte 177 must read 0x4A. Any other value ends the run after that read with `hdr_error` = 1 and `err_code` = 1.
- R3: Organization byte 178, bit 0 (first profile enable) equal to 0 ends the run after that read with `err_code` = 2.
- R4: Revision byte 179 holds the major level in bits 7:4 and the minor level in bits 3:0. A major level other than 1 ends the run after that read with `err_code` = 3.
- R5: A zero in any timebase byte that is read (180 and 181 always, 182 and 183 only when the minor level is nonzero) ends the run after that read with `err_code` = 4.
- R6: With minor level 0, only bytes 176..181 are read, and the second profile reports the pair from 180/181. With a nonzero minor level, bytes 182/183 are also read and become the second profile's pair. The first profile always uses 180 (dividend) and 181 (divisor).
- R7: On success, `prof_en` = byte178[1:0]. `p1_mpc` = byte178[3:2] + 1 and `p2_mpc` = byte178[5:4] + 1, giving a value of 1 to 4. When the second profile is disabled, its modules-per-channel value and its timebase outputs read 0.
- R8: Nonzero bits 7:6 of byte 178 set `hdr_warn` without changing `hdr_valid`. `hdr_warn` stays 0 if the run stops before byte 178 is read.
- R9: `done` is high for exactly one cycle at the end of a run. In that same cycle, exactly one of `hdr_valid` and `hdr_error` is set. All result outputs then hold until the next accepted `start` clears them.
- R10: After an error, `prof_en`, both modules-per-channel values and all four timebase outputs are 0.
- R11: A `start` that arrives while a run is in progress is ignored. The run in progress completes with its normal reads and result.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a header check (accepted when idle) |
| rd_en | output | 1 | Read request to the configuration store |
| rd_addr | output | AW | Byte address of the request |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle end-of-run pulse |
| hdr_valid | output | 1 | Header accepted |
| hdr_error | output | 1 | Header rejected |
| hdr_warn | output | 1 | Reserved organization bits were nonzero |
| err_code | output | 3 | 0 none, 1 identifier, 2 first profile off, 3 major level, 4 zero timebase |
| prof_en | output | 2 | Enable per profile, bit 0 first |
| p1_mpc | output | 3 | First profile modules per channel |
| p2_mpc | output | 3 | Second profile modules per channel |
| p1_tb_num | output | 8 | First profile timebase dividend |
| p1_tb_den | output | 8 | First profile timebase divisor |
| p2_tb_num | output | 8 | Second profile timebase dividend |
| p2_tb_den | output | 8 | Second profile timebase divisor |

## Verification
The properties assume three things: the store returns the byte exactly one cycle after `rd_en`, the header bytes do not change during a run, and reset is held for at least two cycles. The bench's memory model is a registered array that is written only between runs, before `start` is pulsed. Reset is held for several cycles. The sweeps cover every value of each identifier byte, every organization byte and every revision byte, plus a zero placed in each timebase position under both minor levels.

// File: rtl/prof_hdr_pkg.sv
package prof_hdr_pkg;
  localparam int HDR_BYTES = 8;
  localparam int IDX_W     = $clog2(HDR_BYTES);

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_ID   = 3'd1,
    ERR_NOP1 = 3'd2,
    ERR_REV  = 3'd3,
    ERR_TB   = 3'd4
  } herr_e;

  // position of each byte within the header walk
  localparam logic [IDX_W-1:0] I_ID0 = 3'd0;
  localparam logic [IDX_W-1:0] I_ID1 = 3'd1;
  localparam logic [IDX_W-1:0] I_ORG = 3'd2;
  localparam logic [IDX_W-1:0] I_REV = 3'd3;
  localparam logic [IDX_W-1:0] I_N1  = 3'd4;
  localparam logic [IDX_W-1:0] I_D1  = 3'd5;
  localparam logic [IDX_W-1:0] I_N2  = 3'd6;
  localparam logic [IDX_W-1:0] I_D2  = 3'd7;
endpackage

// File: rtl/prof_hdr_eval.sv
module prof_hdr_eval
  import prof_hdr_pkg::*;
#(
  parameter logic [7:0] ID_HI = 8'h0C,
  parameter logic [7:0] ID_LO = 8'h4A,
  parameter logic [3:0] MAJOR = 4'd1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic [3:0]       minor,
  output herr_e            err,
  output logic             last
);
  always_comb begin
    err  = ERR_NONE;
    last = 1'b0;
    case (idx)
      I_ID0: if (data != ID_HI) err = ERR_ID;
      I_ID1: if (data != ID_LO) err = ERR_ID;
      I_ORG: if (!data[0]) err = ERR_NOP1;
      I_REV: if (data[7:4] != MAJOR) err = ERR_REV;
      I_N1, I_N2: if (data == 8'd0) err = ERR_TB;
      I_D1: begin
        if (data == 8'd0) err = ERR_TB;
        last = (minor == 4'd0);   // shared timebase: second pair is not read
      end
      I_D2: begin
        if (data == 8'd0) err = ERR_TB;
        last = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/prof_hdr_seq.sv
module prof_hdr_seq
  import prof_hdr_pkg::*;
#(
  parameter int AW   = 8,
  parameter int BASE = 176
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic [IDX_W-1:0] idx,
  output logic             launch,
  output logic             check
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CHK} st_e;
  st_e st;

  assign launch = (st == S_IDLE) && start;
  assign check  = (st == S_CHK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      idx     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          rd_en   <= 1'b1;
          rd_addr <= AW'(BASE);
          idx     <= '0;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          rd_en <= 1'b0;
          st    <= S_CHK;
        end
        S_CHK: begin
          if (stop) begin
            st <= S_IDLE;
          end else begin
            rd_en   <= 1'b1;
            rd_addr <= rd_addr + 1'b1;
            idx     <= idx + 1'b1;
            st      <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prof_hdr_check.sv
module prof_hdr_check
  import prof_hdr_pkg::*;
#(
  parameter int         AW    = 8,
  parameter int         BASE  = 176,
  parameter logic [7:0] ID_HI = 8'h0C,
  parameter logic [7:0] ID_LO = 8'h4A,
  parameter logic [3:0] MAJOR = 4'd1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          done,
  output logic          hdr_valid,
  output logic          hdr_error,
  output logic          hdr_warn,
  output logic [2:0]    err_code,
  output logic [1:0]    prof_en,
  output logic [2:0]    p1_mpc,
  output logic [2:0]    p2_mpc,
  output logic [7:0]    p1_tb_num,
  output logic [7:0]    p1_tb_den,
  output logic [7:0]    p2_tb_num,
  output logic [7:0]    p2_tb_den
);
  localparam int NPROF = 2;

  logic [IDX_W-1:0] idx;
  logic             launch, check, last, stop_c, fin;
  herr_e            step_err;

  logic [7:0] org_q;
  logic [3:0] minor_q;
  logic [7:0] tb_q [4];
  logic [7:0] tb_n [4];
  logic       warn_n, ok_n;

  logic  done_q, valid_q, error_q, warn_q;
  herr_e code_q;

  assign stop_c = (step_err != ERR_NONE) || last;
  assign fin    = check && stop_c;
  assign ok_n   = (step_err == ERR_NONE);

  prof_hdr_seq #(.AW(AW), .BASE(BASE)) u_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop_c),
    .rd_en(rd_en), .rd_addr(rd_addr), .idx(idx),
    .launch(launch), .check(check)
  );

  prof_hdr_eval #(.ID_HI(ID_HI), .ID_LO(ID_LO), .MAJOR(MAJOR)) u_eval (
    .idx(idx), .data(rd_data), .minor(minor_q), .err(step_err), .last(last)
  );

  // timebase bytes occupy walk positions 4..7, so idx[2] marks them
  always_comb begin
    tb_n = tb_q;
    if (check && idx[2]) tb_n[idx[1:0]] = rd_data;
  end

  always_comb begin
    if (idx == I_ORG)     warn_n = |rd_data[7:6];
    else if (idx > I_ORG) warn_n = |org_q[7:6];
    else                  warn_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      org_q   <= '0;
      minor_q <= '0;
      tb_q    <= '{default: 8'd0};
    end else if (check) begin
      if (idx == I_ORG) org_q   <= rd_data;
      if (idx == I_REV) minor_q <= rd_data[3:0];
      tb_q <= tb_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      error_q <= 1'b0;
      warn_q  <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      done_q <= fin;
      if (launch) begin
        valid_q <= 1'b0;
        error_q <= 1'b0;
        warn_q  <= 1'b0;
        code_q  <= ERR_NONE;
      end else if (fin) begin
        valid_q <= ok_n;
        error_q <= !ok_n;
        warn_q  <= warn_n;
        code_q  <= step_err;
      end
    end
  end

  for (genvar p = 0; p < NPROF; p++) begin : g_prof
    localparam bit SECOND = (p != 0);
    logic       own, en_n, en_q;
    logic [2:0] mpc_n, mpc_q;
    logic [7:0] num_n, den_n, num_q, den_q;

    assign own = SECOND && (minor_q != 4'd0);

    always_comb begin
      en_n  = ok_n && org_q[p];
      mpc_n = en_n ? ({1'b0, org_q[2+2*p +: 2]} + 3'd1) : 3'd0;
      num_n = en_n ? (own ? tb_n[2] : tb_n[0]) : 8'd0;
      den_n = en_n ? (own ? tb_n[3] : tb_n[1]) : 8'd0;
    end

    always_ff @(posedge clk) begin
      if (rst || launch) begin
        en_q  <= 1'b0;
        mpc_q <= '0;
        num_q <= '0;
        den_q <= '0;
      end else if (fin) begin
        en_q  <= en_n;
        mpc_q <= mpc_n;
        num_q <= num_n;
        den_q <= den_n;
      end
    end
  end

  assign done      = done_q;
  assign hdr_valid = valid_q;
  assign hdr_error = error_q;
  assign hdr_warn  = warn_q;
  assign err_code  = code_q;
  assign prof_en   = {g_prof[1].en_q, g_prof[0].en_q};
  assign p1_mpc    = g_prof[0].mpc_q;
  assign p2_mpc    = g_prof[1].mpc_q;
  assign p1_tb_num = g_prof[0].num_q;
  assign p1_tb_den = g_prof[0].den_q;
  assign p2_tb_num = g_prof[1].num_q;
  assign p2_tb_den = g_prof[1].den_q;
endmodule

// File: rtl/prof_hdr_sva.sv
module prof_hdr_sva #(
  parameter int AW   = 8,
  parameter int BASE = 176
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          done,
  input logic          hdr_valid,
  input logic          hdr_error,
  input logic          hdr_warn,
  input logic [2:0]    err_code,
  input logic [1:0]    prof_en,
  input logic [2:0]    p1_mpc,
  input logic [2:0]    p2_mpc,
  input logic [7:0]    p1_tb_num,
  input logic [7:0]    p1_tb_den,
  input logic [7:0]    p2_tb_num,
  input logic [7:0]    p2_tb_den
);
  localparam logic [AW-1:0] FIRST_A = AW'(BASE);
  localparam logic [AW-1:0] LAST_A  = AW'(BASE + 7);

  a_r1_addr_window: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr >= FIRST_A && rd_addr <= LAST_A));

  a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_en) && rd_addr != FIRST_A) |-> (rd_addr == $past(rd_addr) + 1'b1));

  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> (hdr_valid ^ hdr_error));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    ((hdr_valid || hdr_error) && !start) |=>
      $stable({hdr_valid, hdr_error, hdr_warn, err_code, prof_en, p1_mpc, p2_mpc}));

  a_r10_error_clears: assert property (@(posedge clk) disable iff (rst)
    hdr_error |-> (prof_en == 2'b00 && p1_mpc == 3'd0 && p2_mpc == 3'd0
                   && p1_tb_num == 8'd0 && p2_tb_den == 8'd0 && err_code != 3'd0));

  a_r7_first_on: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> (prof_en[0] && p1_mpc != 3'd0 && p1_tb_num != 8'd0 && p1_tb_den != 8'd0));
endmodule

bind prof_hdr_check prof_hdr_sva #(.AW(AW), .BASE(BASE)) u_sva (.*);

// File: tb/prof_hdr_check_test.sv
module prof_hdr_check_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       done, hdr_valid, hdr_error, hdr_warn;
  logic [2:0] err_code, p1_mpc, p2_mpc;
  logic [1:0] prof_en;
  logic [7:0] p1_tb_num, p1_tb_den, p2_tb_num, p2_tb_den;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  prof_hdr_check uut (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .hdr_valid(hdr_valid), .hdr_error(hdr_error),
    .hdr_warn(hdr_warn), .err_code(err_code), .prof_en(prof_en), .p1_mpc(p1_mpc),
    .p2_mpc(p2_mpc), .p1_tb_num(p1_tb_num), .p1_tb_den(p1_tb_den),
    .p2_tb_num(p2_tb_num), .p2_tb_den(p2_tb_den)
  );

  // configuration store: registered, one cycle read latency
  logic [7:0] mem [256];
  int rd_cnt = 0;
  bit addr_bad = 1'b0;
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      if (int'(rd_addr) != 176 + rd_cnt) addr_bad = 1'b1;
      rd_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [45:0] outs();
    return {hdr_valid, hdr_error, hdr_warn, err_code, prof_en, p1_mpc, p2_mpc,
            p1_tb_num, p1_tb_den, p2_tb_num, p2_tb_den};
  endfunction

  // expected results, from the requirements
  int         e_n;
  logic [2:0] e_code;
  logic       e_warn;
  logic [1:0] e_en;
  logic [2:0] e_m1, e_m2;
  logic [31:0] e_tb;

  task automatic predict(input logic [7:0] hb [8]);
    e_code = 3'd0; e_warn = 1'b0;
    if (hb[0] != 8'h0C)             begin e_code = 3'd1; e_n = 1; end
    else if (hb[1] != 8'h4A)        begin e_code = 3'd1; e_n = 2; end
    else begin
      e_warn = (hb[2][7:6] != 2'b00);
      if (!hb[2][0])                begin e_code = 3'd2; e_n = 3; end
      else if (hb[3][7:4] != 4'd1)  begin e_code = 3'd3; e_n = 4; end
      else if (hb[4] == 0)          begin e_code = 3'd4; e_n = 5; end
      else if (hb[5] == 0)          begin e_code = 3'd4; e_n = 6; end
      else if (hb[3][3:0] == 0)     e_n = 6;
      else if (hb[6] == 0)          begin e_code = 3'd4; e_n = 7; end
      else if (hb[7] == 0)          begin e_code = 3'd4; e_n = 8; end
      else                          e_n = 8;
    end
    if (e_code == 3'd0) begin
      e_en = hb[2][1:0];
      e_m1 = 3'(hb[2][3:2]) + 3'd1;
      e_m2 = hb[2][1] ? 3'(hb[2][5:4]) + 3'd1 : 3'd0;
      e_tb[31:16] = {hb[4], hb[5]};
      e_tb[15:0]  = !hb[2][1] ? 16'd0 : (hb[3][3:0] == 0) ? {hb[4], hb[5]} : {hb[6], hb[7]};
    end else begin
      e_en = 2'b00; e_m1 = 3'd0; e_m2 = 3'd0; e_tb = 32'd0;
    end
  endtask

  task automatic run(input logic [7:0] hb [8], input int restart_at);
    string ctag;
    bit got = 1'b0;
    logic [45:0] snap;
    for (int i = 0; i < 8; i++) mem[176 + i] = hb[i];
    predict(hb);
    case (e_code)
      3'd1: ctag = "R2";
      3'd2: ctag = "R3";
      3'd3: ctag = "R4";
      3'd4: ctag = "R5";
      default: ctag = "R6";
    endcase
    rd_cnt = 0; addr_bad = 1'b0;
    start = 1'b1;
    @(negedge clk);
    for (int c = 1; c <= 60; c++) begin
      start = (c == restart_at);
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    start = 1'b0;
    if (!got) begin
      n_tests++; n_fail++;
      $display("FAIL R9: actual no done expected done within 60 cycles");
      return;
    end
    chk(restart_at != 0 ? "R11 reads" : "R1 reads", 64'(rd_cnt), 64'(e_n));
    chk("R1 order", 64'(addr_bad), 64'd0);
    chk(ctag, {hdr_valid, hdr_error, err_code}, {e_code == 0, e_code != 0, e_code});
    chk(e_code != 0 ? "R10" : "R7", {prof_en, p1_mpc, p2_mpc}, {e_en, e_m1, e_m2});
    chk(e_code != 0 ? "R10 tb" : "R6 tb", {p1_tb_num, p1_tb_den, p2_tb_num, p2_tb_den}, e_tb);
    chk("R8", 64'(hdr_warn), 64'(e_warn));
    snap = outs();
    @(negedge clk);
    chk("R9 pulse", 64'(done), 64'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold", 64'(snap), 64'(outs()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R9: actual watchdog expired expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] good [8];
    logic [7:0] hb [8];
    for (int a = 0; a < 256; a++) mem[a] = 8'hA5;
    good = '{8'h0C, 8'h4A, 8'h17, 8'h11, 8'd1, 8'd8, 8'd1, 8'd12};

    repeat (5) @(negedge clk);
    chk("R12", {rd_en, done, outs()}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // identifier bytes, every value (R2)
    for (int v = 0; v < 256; v++) begin hb = good; hb[0] = 8'(v); run(hb, 0); end
    for (int v = 0; v < 256; v++) begin hb = good; hb[1] = 8'(v); run(hb, 0); end
    // organization byte, every value (R3, R7, R8)
    for (int v = 0; v < 256; v++) begin hb = good; hb[2] = 8'(v); run(hb, 0); end
    // revision byte, every value (R4, R6)
    for (int v = 0; v < 256; v++) begin hb = good; hb[3] = 8'(v); hb[2] = 8'h27; run(hb, 0); end
    // zero timebase in each position under both minor levels (R5, R6)
    for (int m = 0; m < 2; m++)
      for (int p = 4; p < 8; p++) begin
        hb = good; hb[3] = m ? 8'h11 : 8'h10; hb[p] = 8'd0; run(hb, 0);
      end
    // start while busy is ignored (R11)
    hb = good; hb[4] = 8'd3; hb[5] = 8'd16; run(hb, 4);
    hb = good; hb[3] = 8'h10; run(hb, 7);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule